// File: doc/BRIEF.md
# Transfer Byte Counter With Identity Readback

This block holds the byte count for a transfer run by a bus-mastering DMA engine. Software writes the count one byte at a time into three staging bytes (low, middle, high). These bytes stay hidden until a command arrives with the DMA flag set. That command copies the staged value into the live counter. Reads of the three count addresses always return the live counter, not the staged value. There is one exception: until software writes the high byte for the first time after reset, reading that address returns a fixed identity constant.

When a DMA transfer command starts, the block works out the effective length. A staged count of zero stands for 65536 bytes. The effective length is the smaller of that count and the magnitude of the signed pending-data count. In command-collect mode the limit is the command buffer size instead of the pending count. The live counter is loaded with this effective length. It then drops by one for each moved byte that the data path reports. When it reaches zero the block flags terminal count and gives a one-cycle completion event. The system uses that event to post a bus-service cause and to clear the sequence step and FIFO flags.

Top module: `dma_xfer_counter`

## Requirements
- R1: While reset is asserted, and after it is released, terminal count, DMA mode, the active flag and the completion event are all 0. The live counter reads 0 at select 0 (low, bits 7:0) and select 1 (middle, bits 15:8). Select 2 (high, bits 23:16) reads CHIP_ID.
- R2: A write to a count select changes only the staged byte, so the readback stays the same. A command with cmd_dma=1 copies all three staged bytes into the live counter and sets dma_mode to 1.
- R3: A command with cmd_dma=0 sets dma_mode to 0 and leaves the live counter unchanged.
- R4: Any write to select 0, 1 or 2 clears terminal count at the next edge, unless a completion happens at the same edge.
- R5: Select 2 reads CHIP_ID until the first write to select 2 after reset. After that write it reads live counter bits 23:16.
- R6: eff_len = min(C, L). C is the staged count, or 0x10000 when the staged count is zero. L is CMDBUF_BYTES when cmd_collect=1, and otherwise the magnitude of the signed pend_cnt. A command with cmd_dma=1 and cmd_xfer=1 loads eff_len into the live counter, clears terminal count and sets xfer_active.
- R7: Each xfer_byte pulse while xfer_active=1 lowers the live counter by one. When the counter reaches zero, the following happen at that edge: terminal count is set, done_evt is 1 for exactly one cycle, and xfer_active clears. xfer_byte pulses while inactive have no effect.
- R8: A DMA transfer command whose eff_len is 0 completes at once: terminal count is set, done_evt is 1, xfer_active is 0 and the counter reads 0.
- R9: If the final xfer_byte and a count-byte write fall in the same cycle, terminal count ends set and done_evt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Count byte write strobe |
| reg_sel | input | 2 | Count byte select: 0 low, 1 middle, 2 high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected live byte or the identity |
| cmd_wr | input | 1 | Command strobe |
| cmd_dma | input | 1 | Command DMA flag |
| cmd_xfer | input | 1 | Command is a transfer start |
| cmd_collect | input | 1 | Command-collect mode: limit by buffer size |
| pend_cnt | input | 25 | Signed pending data count |
| xfer_byte | input | 1 | One byte moved by the data path |
| eff_len | output | 24 | Resolved effective transfer length |
| tc_flag | output | 1 | Terminal count status |
| done_evt | output | 1 | One-cycle completion event |
| dma_mode | output | 1 | Last command selected DMA |
| xfer_active | output | 1 | Transfer in progress |

## Verification
Completion and the clearing of terminal count by a count-byte write can land on the same clock edge. To provoke this, a one-byte transfer is started, and then the last xfer_byte pulse is driven in the same cycle as a write to the middle count byte. The bench judges the result at the following falling edge: terminal count must be set and done_evt must be high, so the completion takes precedence over the clear.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_MID = 2'd1,
    SEL_HI  = 2'd2
  } cnt_sel_e;

  function automatic logic [24:0] mag25(input logic signed [24:0] v);
    mag25 = v[24] ? 25'(-v) : 25'(v);
  endfunction
endpackage

// File: rtl/dxc_shadow_regs.sv
module dxc_shadow_regs #(
  parameter int unsigned CNT_BYTES = 3,
  localparam int unsigned CNT_W = CNT_BYTES * 8,
  localparam int unsigned SEL_W = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic             hi_written_o,
  output logic             cnt_write_o
);
  localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(CNT_BYTES - 1);

  logic [CNT_W-1:0] shd_q, shd_d;
  logic             hiw_q, hiw_d;
  logic             sel_ok;

  assign sel_ok = (sel_i <= HI_SEL);

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_byte
    logic hit;
    assign hit = wr_i && (sel_i == SEL_W'(b));
    always_comb begin
      shd_d[b*8 +: 8] = shd_q[b*8 +: 8];
      if (hit) shd_d[b*8 +: 8] = wdata_i;
    end
  end

  always_comb begin
    hiw_d = hiw_q;
    if (wr_i && sel_i == HI_SEL) hiw_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      hiw_q <= 1'b0;
    end else begin
      shd_q <= shd_d;
      hiw_q <= hiw_d;
    end
  end

  assign shadow_o     = shd_q;
  assign hi_written_o = hiw_q;
  assign cnt_write_o  = wr_i && sel_ok;

  // R5
  hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_i && sel_i == HI_SEL) |=> hi_written_o);
  // R5
  hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    hi_written_o |=> hi_written_o);
endmodule

// File: rtl/dxc_len_resolve.sv
module dxc_len_resolve #(
  parameter int unsigned CNT_BYTES    = 3,
  parameter int unsigned ZERO_LEN     = 32'h10000,
  parameter int unsigned CMDBUF_BYTES = 32,
  localparam int unsigned CNT_W  = CNT_BYTES * 8,
  localparam int unsigned PEND_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PEND_W-1:0] pend_i,
  input  logic              collect_i,
  output logic [CNT_W-1:0]  eff_o
);
  logic [PEND_W-1:0] cnt_eff, lim, mag;

  always_comb begin
    if (pend_i[PEND_W-1]) mag = PEND_W'(-pend_i);
    else                  mag = pend_i;
    cnt_eff = (count_i == '0) ? PEND_W'(ZERO_LEN) : PEND_W'(count_i);
    lim     = collect_i ? PEND_W'(CMDBUF_BYTES) : mag;
    eff_o   = (cnt_eff < lim) ? CNT_W'(cnt_eff) : CNT_W'(lim);
  end

  // R6
  eff_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (collect_i || pend_i != '0) |-> (eff_o != '0));
  // R6
  eff_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (count_i != '0) |-> (eff_o <= count_i));
endmodule

// File: rtl/dxc_live_counter.sv
module dxc_live_counter #(
  parameter int unsigned CNT_BYTES = 3,
  localparam int unsigned CNT_W = CNT_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_len_i,
  input  logic             dec_i,
  input  logic             tc_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o,
  output logic             active_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tc_q, tc_d;
  logic             act_q, act_d;
  logic             done_q, done_d;
  logic             fin;
  logic             step;

  assign step = act_q && dec_i && !start_i && !load_i && (cnt_q != '0);
  assign fin  = (start_i && start_len_i == '0) ||
                (step && cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    tc_d   = tc_q;
    done_d = fin;
    if (start_i) begin
      cnt_d = start_len_i;
      act_d = (start_len_i != '0);
      tc_d  = 1'b0;
    end else if (load_i) begin
      cnt_d = load_val_i;
      act_d = 1'b0;
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) act_d = 1'b0;
    end
    if (tc_clr_i) tc_d = 1'b0;
    if (fin)      tc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tc_q   <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tc_q   <= tc_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign tc_o     = tc_q;
  assign active_o = act_q;
  assign done_o   = done_q;

  // R7
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (tc_o && !active_o && cnt_o == '0));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
  // R7
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (active_o && dec_i && !start_i && !load_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!active_o && !start_i && !load_i) |=> $stable(cnt_o));
  // R4
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tc_clr_i && !fin) |=> !tc_o);
  // R6
  start_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_i && start_len_i != '0) |=> (active_o && !tc_o));
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int unsigned CNT_BYTES    = 3,
  parameter int unsigned ZERO_LEN     = 32'h10000,
  parameter int unsigned CMDBUF_BYTES = 32,
  parameter logic [7:0]  CHIP_ID      = 8'hA2,
  localparam int unsigned CNT_W  = CNT_BYTES * 8,
  localparam int unsigned PEND_W = CNT_W + 1,
  localparam int unsigned SEL_W  = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cmd_wr,
  input  logic              cmd_dma,
  input  logic              cmd_xfer,
  input  logic              cmd_collect,
  input  logic [PEND_W-1:0] pend_cnt,
  input  logic              xfer_byte,
  output logic [CNT_W-1:0]  eff_len,
  output logic              tc_flag,
  output logic              done_evt,
  output logic              dma_mode,
  output logic              xfer_active
);
  localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(CNT_BYTES - 1);

  logic             rst_s1_q, rst_s2_q;
  logic             rst_i;
  logic [CNT_W-1:0] shadow, live;
  logic             hi_written, cnt_write;
  logic             dma_q, dma_d;
  logic             load, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  dxc_shadow_regs #(.CNT_BYTES(CNT_BYTES)) u_shadow (
    .clk          (clk),
    .rst_ni       (rst_i),
    .wr_i         (reg_wr),
    .sel_i        (reg_sel),
    .wdata_i      (reg_wdata),
    .shadow_o     (shadow),
    .hi_written_o (hi_written),
    .cnt_write_o  (cnt_write)
  );

  dxc_len_resolve #(
    .CNT_BYTES    (CNT_BYTES),
    .ZERO_LEN     (ZERO_LEN),
    .CMDBUF_BYTES (CMDBUF_BYTES)
  ) u_resolve (
    .clk       (clk),
    .rst_ni    (rst_i),
    .count_i   (shadow),
    .pend_i    (pend_cnt),
    .collect_i (cmd_collect),
    .eff_o     (eff_len)
  );

  assign load  = cmd_wr && cmd_dma;
  assign start = load && cmd_xfer;

  dxc_live_counter #(.CNT_BYTES(CNT_BYTES)) u_counter (
    .clk         (clk),
    .rst_ni      (rst_i),
    .load_i      (load),
    .load_val_i  (shadow),
    .start_i     (start),
    .start_len_i (eff_len),
    .dec_i       (xfer_byte),
    .tc_clr_i    (cnt_write),
    .cnt_o       (live),
    .tc_o        (tc_flag),
    .active_o    (xfer_active),
    .done_o      (done_evt)
  );

  always_comb begin
    dma_d = dma_q;
    if (cmd_wr) dma_d = cmd_dma;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) dma_q <= 1'b0;
    else        dma_q <= dma_d;
  end
  assign dma_mode = dma_q;

  always_comb begin
    reg_rdata = 8'h00;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (reg_sel == SEL_W'(b)) reg_rdata = live[b*8 +: 8];
    end
    if (reg_sel == HI_SEL && !hi_written) reg_rdata = CHIP_ID;
  end

  // R2
  reload_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (load && !cmd_xfer) |=> (live == $past(shadow) && dma_mode));
  // R3
  pio_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_wr && !cmd_dma && !xfer_active) |=> (!dma_mode && $stable(live)));
endmodule

// File: tb/dma_xfer_counter_bench.sv
module dma_xfer_counter_bench;
  localparam logic [7:0] ID = 8'hA2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, cmd_wr, cmd_dma, cmd_xfer, cmd_collect, xfer_byte;
  logic [1:0]  reg_sel;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [24:0] pend_cnt;
  logic [23:0] eff_len;
  logic        tc_flag, done_evt, dma_mode, xfer_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dma_xfer_counter #(.CHIP_ID(ID)) u_dma_xfer_counter (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .cmd_wr, .cmd_dma, .cmd_xfer, .cmd_collect, .pend_cnt, .xfer_byte,
    .eff_len, .tc_flag, .done_evt, .dma_mode, .xfer_active
  );

  // {staged count, pend_cnt, collect, expected eff_len}
  localparam logic [73:0] VEC [7] = '{
    {24'h000010, 25'h0000020, 1'b0, 24'h000010},
    {24'h000000, 25'h0020000, 1'b0, 24'h010000},
    {24'h000000, 25'h0000005, 1'b0, 24'h000005},
    {24'h000100, 25'h1FFFFC0, 1'b0, 24'h000040},
    {24'h123456, 25'h0000000, 1'b1, 24'h000020},
    {24'h000008, 25'h0000000, 1'b1, 24'h000008},
    {24'h030000, 25'h0FFFFFF, 1'b0, 24'h030000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    reg_wr = 0; cmd_wr = 0; xfer_byte = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    tick();
  endtask

  task automatic stage(input logic [23:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]); wr(2'd2, v[23:16]);
  endtask

  task automatic cmd(input logic dma, input logic xf);
    cmd_wr = 1; cmd_dma = dma; cmd_xfer = xf;
    tick();
  endtask

  task automatic rd(input string req, input logic [1:0] s, input logic [7:0] exp);
    reg_sel = s; #1;
    check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; cmd_wr = 0; cmd_dma = 0; cmd_xfer = 0;
    cmd_collect = 0; xfer_byte = 0; reg_sel = 0; reg_wdata = 0; pend_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tc", {31'h0, tc_flag}, 0);
    check("R1 dma", {31'h0, dma_mode}, 0);
    check("R1 active", {31'h0, xfer_active}, 0);
    check("R1 done", {31'h0, done_evt}, 0);
    rd("R1 lo", 2'd0, 8'h00);
    rd("R1 mid", 2'd1, 8'h00);
    rd("R1 hi id", 2'd2, ID);

    // R2 staged bytes hidden; R5 identity persists
    wr(2'd0, 8'h05); wr(2'd1, 8'h00);
    rd("R2 hidden", 2'd0, 8'h00);
    rd("R5 id kept", 2'd2, ID);
    wr(2'd2, 8'h00);
    rd("R5 hi live", 2'd2, 8'h00);
    cmd(1'b1, 1'b0);
    rd("R2 reload", 2'd0, 8'h05);
    check("R2 dma", {31'h0, dma_mode}, 1);

    // R3 non-DMA command
    cmd(1'b0, 1'b0);
    check("R3 dma", {31'h0, dma_mode}, 0);
    rd("R3 hold", 2'd0, 8'h05);

    // R6 length resolution table
    for (int i = 0; i < 7; i++) begin
      stage(VEC[i][73:50]);
      pend_cnt = VEC[i][49:25];
      cmd_collect = VEC[i][24];
      #1;
      check("R6 eff", {8'h0, eff_len}, {8'h0, VEC[i][23:0]});
    end
    cmd_collect = 0;

    // R6/R7 transfer
    stage(24'h000005); pend_cnt = 25'd3;
    cmd(1'b1, 1'b1);
    check("R6 active", {31'h0, xfer_active}, 1);
    check("R6 tc", {31'h0, tc_flag}, 0);
    rd("R6 load", 2'd0, 8'h03);
    xfer_byte = 1; tick();
    rd("R7 dec", 2'd0, 8'h02);
    xfer_byte = 1; tick();
    xfer_byte = 1; tick();
    rd("R7 zero", 2'd0, 8'h00);
    rd("R7 hi zero", 2'd2, 8'h00);
    check("R7 tc", {31'h0, tc_flag}, 1);
    check("R7 done", {31'h0, done_evt}, 1);
    check("R7 idle", {31'h0, xfer_active}, 0);
    xfer_byte = 1; tick();
    check("R7 done once", {31'h0, done_evt}, 0);
    rd("R7 ignored", 2'd0, 8'h00);
    check("R7 tc kept", {31'h0, tc_flag}, 1);

    // R4 count write clears tc
    wr(2'd0, 8'h07);
    check("R4 clr lo", {31'h0, tc_flag}, 0);

    // R8 zero effective length
    pend_cnt = 25'd0;
    cmd(1'b1, 1'b1);
    check("R8 tc", {31'h0, tc_flag}, 1);
    check("R8 done", {31'h0, done_evt}, 1);
    check("R8 idle", {31'h0, xfer_active}, 0);
    rd("R8 zero", 2'd0, 8'h00);
    wr(2'd2, 8'h00);
    check("R4 clr hi", {31'h0, tc_flag}, 0);

    // R9 final byte and count write together
    wr(2'd0, 8'h05); pend_cnt = 25'd1;
    cmd(1'b1, 1'b1);
    rd("R9 load", 2'd0, 8'h01);
    xfer_byte = 1; reg_sel = 2'd1; reg_wdata = 8'h00; reg_wr = 1;
    tick();
    check("R9 tc", {31'h0, tc_flag}, 1);
    check("R9 done", {31'h0, done_evt}, 1);

    // R1 asynchronous reset mid-run
    rst_n = 0; #1;
    rd("R1 async id", 2'd2, ID);
    check("R1 async tc", {31'h0, tc_flag}, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule